// File: doc/BRIEF.md
# 64-bit Integer Add Unit with 32-bit Saturating Forms

This block is the add and subtract lane of a scalar integer datapath. It takes two 64-bit register operands, a 16-bit immediate and a 5-bit operation code. It returns one registered 64-bit result in the cycle after the inputs are offered. The operations are grouped into a few families:

- plain 64-bit add and subtract, which wrap
- narrow "x" forms, which compute at full width and then sign-extend bit 31
- signed 32-bit saturating add and subtract
- scaled-index adds, where srcA is shifted left by 1, 2 or 3 before the add
- add-immediate forms, with a short immediate and a long immediate
- a shift-left-by-16 that ORs in a 16-bit constant

When the operation code matches none of these, the block raises an unsupported flag and returns no result value.

Register files, instruction decode and pipeline control stay in the parent. A valid input is consumed in the cycle it is presented, and there is no backpressure. When no input is valid, the result and the flag keep their last values.

Top module: `int_alu`

## Requirements
- R1: While rst_ni is low, out_valid_o, unsup_o and result_o are all zero.
- R2: out_valid_o is high exactly in the cycle after a cycle with in_valid_i high. After a cycle without in_valid_i, result_o and unsup_o keep their previous values.
- R3: Code 0 returns src_a + src_b and code 1 returns src_a - src_b, both modulo 2^64.
- R4: Code 2 (add) and code 3 (subtract) compute at 64 bits, then return bits 31:0 of the sum or difference, sign-extended from bit 31.
- R5: Code 4 (add) and code 5 (subtract) sign-extend bits 31:0 of each operand and form the exact sum or difference. They clamp it to the range -0x80000000..0x7FFFFFFF and return it sign-extended to 64 bits. Operand bits 63:32 have no effect.
- R6: Codes 6, 7 and 8 return (src_a << N) + src_b modulo 2^64, with N = 1, 2 and 3 respectively.
- R7: Codes 9, 10 and 11 compute the same scaled sums with N = 1, 2 and 3, then return bits 31:0 sign-extended from bit 31.
- R8: Code 12 returns src_a plus imm_i[7:0] sign-extended to 64 bits. Code 14 returns src_a plus imm_i[15:0] sign-extended to 64 bits. Both wrap modulo 2^64.
- R9: Code 13 (short immediate) and code 15 (long immediate) form the same sums as R8, then return bits 31:0 sign-extended from bit 31.
- R10: Code 16 returns (src_a << 16) OR the zero-extended imm_i[15:0]. src_b has no effect.
- R11: Codes 17 to 31 set unsup_o to 1 and result_o to zero. Every supported code sets unsup_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands and code are valid this cycle |
| op_i | input | 5 | Operation code |
| src_a_i | input | 64 | First operand |
| src_b_i | input | 64 | Second operand |
| imm_i | input | 16 | Immediate |
| out_valid_o | output | 1 | Result is valid |
| result_o | output | 64 | Registered result |
| unsup_o | output | 1 | Operation code not supported |

## Verification
The saturating forms are driven at both clamp edges: 0x7FFFFFFF + 1, -0x80000000 - 1, and the cases where subtracting -1 or adding -1 pushes past a limit. These separate a correct clamp from wrap-around and from a clamp placed at the wrong width. Operands with nonzero upper words are sent to every 32-bit form. They show whether the narrow paths look only at bits 31:0, and whether the "x" forms sign-extend from bit 31 rather than saturate. The scaled adds, the immediate adds and the shift-insert use operands whose shifted-out bits, immediate sign bits and upper immediate byte differ. This exposes a wrong shift amount, a wrong immediate width, or an src_b that leaks into the shift-insert. A long run of pseudo-random operands across all supported codes, mixed with unsupported codes and idle gaps, is then checked against an independent reference model.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  localparam int DATA_W   = 64;
  localparam int NARROW_W = 32;
  localparam int IMM_W    = 16;
  localparam int SIMM_W   = 8;
  localparam int OP_W     = 5;
  localparam int INS_SH   = 16;
  localparam int N_SCALE  = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD     = 5'd0,
    OP_SUB     = 5'd1,
    OP_ADDX    = 5'd2,
    OP_SUBX    = 5'd3,
    OP_ADDSAT  = 5'd4,
    OP_SUBSAT  = 5'd5,
    OP_SC1     = 5'd6,
    OP_SC2     = 5'd7,
    OP_SC3     = 5'd8,
    OP_SC1X    = 5'd9,
    OP_SC2X    = 5'd10,
    OP_SC3X    = 5'd11,
    OP_ADDIS   = 5'd12,
    OP_ADDIXS  = 5'd13,
    OP_ADDIL   = 5'd14,
    OP_ADDIXL  = 5'd15,
    OP_SHINS   = 5'd16
  } alu_op_e;

  function automatic logic [DATA_W-1:0] sext_narrow(input logic [NARROW_W-1:0] v);
    return {{(DATA_W-NARROW_W){v[NARROW_W-1]}}, v};
  endfunction
endpackage

// File: rtl/narrow_sat.sv
module narrow_sat #(
  parameter int DW = 64,
  parameter int NW = 32
) (
  input  logic [NW-1:0] a_i,
  input  logic [NW-1:0] b_i,
  input  logic          sub_i,
  output logic [DW-1:0] res_o
);
  localparam int EW = NW + 2;
  localparam logic signed [EW-1:0] SAT_MAX = {3'b000, {(NW-1){1'b1}}};
  localparam logic signed [EW-1:0] SAT_MIN = {3'b111, {(NW-1){1'b0}}};

  logic signed [EW-1:0] ea, eb, exact;
  logic [NW-1:0] clamped;

  always_comb begin
    ea    = {{2{a_i[NW-1]}}, a_i};
    eb    = {{2{b_i[NW-1]}}, b_i};
    exact = sub_i ? (ea - eb) : (ea + eb);
    if (exact > SAT_MAX)      clamped = SAT_MAX[NW-1:0];
    else if (exact < SAT_MIN) clamped = SAT_MIN[NW-1:0];
    else                      clamped = exact[NW-1:0];
    res_o = {{(DW-NW){clamped[NW-1]}}, clamped};
  end
endmodule

// File: rtl/scaled_adder.sv
module scaled_adder #(
  parameter int DW    = 64,
  parameter int SHIFT = 1
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] sum_o
);
  assign sum_o = (a_i << SHIFT) + b_i;
endmodule

// File: rtl/imm_adder.sv
module imm_adder #(
  parameter int DW = 64,
  parameter int IW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [IW-1:0] imm_i,
  output logic [DW-1:0] sum_o
);
  assign sum_o = a_i + {{(DW-IW){imm_i[IW-1]}}, imm_i};
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              unsup_o
);
  logic [DATA_W-1:0] sum_full, diff_full, shins;
  logic [DATA_W-1:0] sat_res [2];
  logic [DATA_W-1:0] sc_sum  [N_SCALE];
  logic [DATA_W-1:0] imm_s_sum, imm_l_sum;
  logic [DATA_W-1:0] res_d;
  logic              unsup_d;

  assign sum_full  = src_a_i + src_b_i;
  assign diff_full = src_a_i - src_b_i;
  assign shins     = (src_a_i << INS_SH) | {{(DATA_W-IMM_W){1'b0}}, imm_i};

  // index 0: add, index 1: subtract
  for (genvar g = 0; g < 2; g++) begin : g_sat
    narrow_sat #(.DW(DATA_W), .NW(NARROW_W)) i_sat (
      .a_i   (src_a_i[NARROW_W-1:0]),
      .b_i   (src_b_i[NARROW_W-1:0]),
      .sub_i (g == 1),
      .res_o (sat_res[g])
    );
  end

  for (genvar g = 0; g < N_SCALE; g++) begin : g_scale
    scaled_adder #(.DW(DATA_W), .SHIFT(g + 1)) i_sc (
      .a_i   (src_a_i),
      .b_i   (src_b_i),
      .sum_o (sc_sum[g])
    );
  end

  imm_adder #(.DW(DATA_W), .IW(SIMM_W)) i_imm_s (
    .a_i   (src_a_i),
    .imm_i (imm_i[SIMM_W-1:0]),
    .sum_o (imm_s_sum)
  );

  imm_adder #(.DW(DATA_W), .IW(IMM_W)) i_imm_l (
    .a_i   (src_a_i),
    .imm_i (imm_i),
    .sum_o (imm_l_sum)
  );

  always_comb begin
    unsup_d = 1'b0;
    res_d   = '0;
    case (op_i)
      OP_ADD:    res_d = sum_full;
      OP_SUB:    res_d = diff_full;
      OP_ADDX:   res_d = sext_narrow(sum_full[NARROW_W-1:0]);
      OP_SUBX:   res_d = sext_narrow(diff_full[NARROW_W-1:0]);
      OP_ADDSAT: res_d = sat_res[0];
      OP_SUBSAT: res_d = sat_res[1];
      OP_SC1:    res_d = sc_sum[0];
      OP_SC2:    res_d = sc_sum[1];
      OP_SC3:    res_d = sc_sum[2];
      OP_SC1X:   res_d = sext_narrow(sc_sum[0][NARROW_W-1:0]);
      OP_SC2X:   res_d = sext_narrow(sc_sum[1][NARROW_W-1:0]);
      OP_SC3X:   res_d = sext_narrow(sc_sum[2][NARROW_W-1:0]);
      OP_ADDIS:  res_d = imm_s_sum;
      OP_ADDIXS: res_d = sext_narrow(imm_s_sum[NARROW_W-1:0]);
      OP_ADDIL:  res_d = imm_l_sum;
      OP_ADDIXL: res_d = sext_narrow(imm_l_sum[NARROW_W-1:0]);
      OP_SHINS:  res_d = shins;
      default:   unsup_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      unsup_o     <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        result_o <= res_d;
        unsup_o  <= unsup_d;
      end
    end
  end

  logic op_is_narrow;
  assign op_is_narrow = op_i inside {OP_ADDX, OP_SUBX, OP_ADDSAT, OP_SUBSAT,
                                     OP_SC1X, OP_SC2X, OP_SC3X, OP_ADDIXS, OP_ADDIXL};

  assert_valid_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  assert_idle_no_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> (!out_valid_o && $stable(result_o) && $stable(unsup_o)));
  assert_narrow_sext_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_is_narrow) |=>
      ($countones(result_o[DATA_W-1:NARROW_W-1]) == 0 ||
       $countones(result_o[DATA_W-1:NARROW_W-1]) == DATA_W-NARROW_W+1));
  assert_sat_pos_no_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == OP_ADDSAT && !src_a_i[NARROW_W-1] && !src_b_i[NARROW_W-1])
      |=> !result_o[DATA_W-1]);
  assert_sat_neg_no_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == OP_ADDSAT && src_a_i[NARROW_W-1] && src_b_i[NARROW_W-1])
      |=> result_o[DATA_W-1]);
  assert_shins_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == OP_SHINS) |=> result_o[IMM_W-1:0] == $past(imm_i));
  assert_unsup_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i > OP_SHINS) |=> (unsup_o && result_o == '0));
  assert_sup_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i <= OP_SHINS) |=> !unsup_o);
endmodule

// File: tb/test_int_alu.sv
`timescale 1ns/100ps
module test_int_alu;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  op = '0;
  logic [63:0] a = '0, b = '0;
  logic [15:0] imm = '0;
  logic        out_valid, unsup;
  logic [63:0] result;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [64:0] exp_q [$];
  string       tag_q [$];
  logic [64:0] last_exp = '0;

  always #2.5 clk = ~clk;

  int_alu i_int_alu (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .op_i(op),
    .src_a_i(a), .src_b_i(b), .imm_i(imm),
    .out_valid_o(out_valid), .result_o(result), .unsup_o(unsup)
  );

  function automatic logic [63:0] sx32(input logic [63:0] v);
    return {{32{v[31]}}, v[31:0]};
  endfunction

  function automatic logic [64:0] model(input logic [4:0] c, input logic [63:0] x,
                                        input logic [63:0] y, input logic [15:0] k);
    longint xs, ys, s;
    logic [63:0] ks, kl;
    xs = longint'($signed(x[31:0]));
    ys = longint'($signed(y[31:0]));
    ks = {{56{k[7]}}, k[7:0]};
    kl = {{48{k[15]}}, k};
    case (c)
      5'd0:  return {1'b0, x + y};
      5'd1:  return {1'b0, x - y};
      5'd2:  return {1'b0, sx32(x + y)};
      5'd3:  return {1'b0, sx32(x - y)};
      5'd4, 5'd5: begin
        s = (c == 5'd4) ? xs + ys : xs - ys;
        if (s > 64'sh7FFFFFFF) s = 64'sh7FFFFFFF;
        if (s < -64'sh80000000) s = -64'sh80000000;
        return {1'b0, s};
      end
      5'd6:  return {1'b0, (x << 1) + y};
      5'd7:  return {1'b0, (x << 2) + y};
      5'd8:  return {1'b0, (x << 3) + y};
      5'd9:  return {1'b0, sx32((x << 1) + y)};
      5'd10: return {1'b0, sx32((x << 2) + y)};
      5'd11: return {1'b0, sx32((x << 3) + y)};
      5'd12: return {1'b0, x + ks};
      5'd13: return {1'b0, sx32(x + ks)};
      5'd14: return {1'b0, x + kl};
      5'd15: return {1'b0, sx32(x + kl)};
      5'd16: return {1'b0, (x << 16) | {48'd0, k}};
      default: return {1'b1, 64'd0};
    endcase
  endfunction

  task automatic check(input bit ok, input string what, input logic [64:0] got,
                       input logic [64:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got unsup=%0b res=%h exp unsup=%0b res=%h",
               what, got[64], got[63:0], exp[64], exp[63:0]);
    end
  endtask

  task automatic drive(input logic [4:0] c, input logic [63:0] x, input logic [63:0] y,
                       input logic [15:0] k, input string tag);
    @(negedge clk);
    op = c; a = x; b = y; imm = k; in_valid = 1'b1;
    exp_q.push_back(model(c, x, y, k));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      a = ~a; b = b ^ 64'h5555; op = op + 5'd1; imm = ~imm;
    end
  endtask

  // monitor: compares each result with the head of the queue
  always @(negedge clk) begin
    if (rst_ni && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected out_valid", {unsup, result}, 65'd0);
      end else begin
        logic [64:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        last_exp = e;
        check({unsup, result} === e, t, {unsup, result}, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && unsup === 1'b0 && result === 64'd0, "R1 reset state",
          {unsup, result}, 65'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    drive(5'd0, 64'h0123_4567_89AB_CDEF, 64'h1111_2222_3333_4444, 16'h0, "R3 add");
    drive(5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 16'h0, "R3 add wrap");
    drive(5'd1, 64'd0, 64'd1, 16'h0, "R3 sub wrap");
    drive(5'd2, 64'h0000_0000_7FFF_FFFF, 64'd1, 16'h0, "R4 addx crosses bit31");
    drive(5'd3, 64'hABCD_0000_0000_0000, 64'h0000_0000_0000_0001, 16'h0, "R4 subx upper bits");
    drive(5'd4, 64'h0000_0000_7FFF_FFFF, 64'd1, 16'h0, "R5 sat add max+1");
    drive(5'd5, 64'hFFFF_FFFF_8000_0000, 64'd1, 16'h0, "R5 sat sub min-1");
    drive(5'd5, 64'h0000_0000_7FFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0, "R5 sat sub max-(-1)");
    drive(5'd4, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 16'h0, "R5 sat add min+(-1) upper zero");
    drive(5'd4, 64'hDEAD_0000_0000_0005, 64'h1234_0000_0000_0003, 16'h0, "R5 upper bits ignored");
    drive(5'd5, 64'h7777_0000_0000_0002, 64'h8888_0000_0000_0009, 16'h0, "R5 sub upper bits ignored");
    drive(5'd6, 64'h8000_0000_0000_0003, 64'd10, 16'h0, "R6 shift1");
    drive(5'd7, 64'hC000_0000_0000_0003, 64'd10, 16'h0, "R6 shift2");
    drive(5'd8, 64'hE000_0000_0000_0003, 64'd10, 16'h0, "R6 shift3");
    drive(5'd9, 64'h0000_0000_4000_0000, 64'd0, 16'h0, "R7 shift1 x");
    drive(5'd10, 64'h1234_0000_2000_0001, 64'd5, 16'h0, "R7 shift2 x");
    drive(5'd11, 64'h0000_0001_1000_0000, 64'd7, 16'h0, "R7 shift3 x");
    drive(5'd12, 64'd100, 64'hFFFF, 16'h12F0, "R8 short imm negative");
    drive(5'd14, 64'd100, 64'hFFFF, 16'h80F0, "R8 long imm negative");
    drive(5'd14, 64'd100, 64'd0, 16'h7FFF, "R8 long imm positive");
    drive(5'd13, 64'h0000_0000_7FFF_FFF0, 64'd0, 16'h0020, "R9 short imm x");
    drive(5'd15, 64'hFFFF_0000_0000_0000, 64'd0, 16'hFFFF, "R9 long imm x");
    drive(5'd16, 64'hABCD_1234_5678_9ABC, 64'hFFFF_FFFF_FFFF_FFFF, 16'hBEEF, "R10 shift insert");
    drive(5'd17, 64'd1, 64'd2, 16'h3, "R11 code 17");
    drive(5'd31, 64'hFFFF, 64'hFFFF, 16'hFFFF, "R11 code 31");
    drive(5'd0, 64'd5, 64'd6, 16'h0, "R11 flag clears");
    idle(3);
    check(out_valid === 1'b0 && {unsup, result} === last_exp, "R2 idle holds",
          {out_valid, result}, last_exp);

    for (int i = 0; i < 300; i++) begin
      logic [4:0] c;
      c = (i % 10 == 9) ? 5'(17 + ($urandom % 15)) : 5'($urandom % 17);
      drive(c, {$urandom, $urandom}, {$urandom, $urandom}, 16'($urandom),
            "R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
      if (i % 37 == 0) idle(2);
    end
    idle(3);
    check(exp_q.size() == 0, "R2 all results delivered", 65'(exp_q.size()), 65'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule